// File: doc/BRIEF.md
# Cipher Unit Reset and Initialization Controller

This block is the control-and-status front end of an encryption execution unit. A word-addressed register port gives software four registers. The reset command register at offset 0x0 is write-only. The status register at 0x4 is read-only and carries a ready flag. The interrupt status register sits at 0x8 and the interrupt enable register at 0xC. Software writes the command register to pick one of three resets, each reaching further than the last. The interrupt reset only clears interrupt state. The partial reset reinitializes the unit but keeps the interrupt enables. The full reset acts like a hardware reset confined to this unit.

After a hardware reset, or after a partial or full reset command, a sequencer writes zero into every entry of a small parameter memory, one entry per clock. The ready flag rises only when the last entry has been written. While the sequencer runs it owns the memory port, and the cipher datapath's write and read port to the memory is shut out. A DONE event from the datapath arrives as a one-cycle pulse. A write to the read-only status register is treated as an address error. Each of these two events latches a status bit, and it drives a registered interrupt line when the matching enable bit is set.

Top module: `cipher_unit_rstctl`

## Requirements
- R1: While and right after the synchronous hardware reset, `bus_rdata`, `irq_done` and `irq_err` are 0 and `unit_ready` is 0. Once ready, the interrupt status and interrupt enable registers read 0.
- R2: After a hardware reset, or after the edge that accepts a partial or full reset command, `unit_ready` (and status bit 0) stays 0 for 63 edges and rises on the 64th. Every parameter memory entry then reads 0.
- R3: A full reset (bit 24 written at offset 0x0) clears the enable register, the status register and both interrupt lines, and it restarts initialization.
- R4: A partial reset (bit 25 at offset 0x0) does the same as a full reset, except that the enable register keeps its value.
- R5: An interrupt reset (bit 26 at offset 0x0) clears the interrupt status register and both interrupt lines. It leaves the enables, `unit_ready` and the memory unchanged.
- R6: When several command bits are written together, full wins over partial, and partial wins over interrupt reset.
- R7: Reading offset 0x0 always returns 0, and a write there with no command bit set has no effect.
- R8: A write to offset 0x4 leaves the status register unchanged and sets interrupt status bit 1 (address error).
- R9: `irq_done` equals interrupt status bit 0 AND enable bit 0, and `irq_err` equals status bit 1 AND enable bit 1. Both update on the same edge as the registers.
- R10: When ready, a write to 0x8 clears each status bit written as 1, and a write to 0xC loads enable bits [1:0]. While ready is low, both writes are ignored, but reads still return the current values.
- R11: A `done_evt` pulse sets interrupt status bit 0. When it falls in the same cycle as an interrupt reset or a write-one-to-clear, the set wins.
- R12: When ready, `pm_we` writes `pm_wdata` to entry `pm_addr`, and `pm_rdata` shows the addressed entry one edge later. Datapath writes while ready is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| done_evt | input | 1 | One-cycle DONE event from the datapath |
| irq_done | output | 1 | DONE interrupt line |
| irq_err | output | 1 | ERROR (address error) interrupt line |
| unit_ready | output | 1 | Initialization complete |
| pm_we | input | 1 | Datapath parameter memory write enable |
| pm_addr | input | $clog2(PM_DEPTH) | Datapath parameter memory address |
| pm_wdata | input | PM_W | Datapath parameter memory write data |
| pm_rdata | output | PM_W | Parameter memory read data |

## Verification
A DONE event can land on the same edge as a clear of the interrupt status, whether that clear is an interrupt reset command or a write-one-to-clear. The bench provokes this by raising `done_evt` in the very cycle of the register write, both in directed cases and at random. A reference model applies the set after the clear and is compared with the status register and `irq_done`. The bench also overlaps datapath memory writes and register writes with a running initialization. It judges them by reading the registers and memory back once ready rises.

// File: rtl/curc_pkg.sv
package curc_pkg;
  // command bit positions in the reset command register
  localparam int unsigned CMD_IRQ_BIT  = 26;
  localparam int unsigned CMD_PART_BIT = 25;
  localparam int unsigned CMD_FULL_BIT = 24;
  // interrupt lines: bit 0 done, bit 1 address error
  localparam int unsigned IRQ_W    = 2;
  localparam int unsigned IDX_DONE = 0;
  localparam int unsigned IDX_AERR = 1;

  typedef enum logic [1:0] {
    SEL_RCR  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_ISR  = 2'd2,
    SEL_ICR  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_IRQCLR,
    CMD_PART,
    CMD_FULL
  } rst_cmd_e;
endpackage

// File: rtl/curc_cmd_decode.sv
module curc_cmd_decode
  import curc_pkg::*;
(
  input  logic       wr_en,
  input  reg_sel_e   sel,
  input  logic [2:0] cmd_bits,   // {irq, part, full}
  output rst_cmd_e   cmd,
  output logic       stat_wr,
  output logic       isr_wr,
  output logic       icr_wr
);
  always_comb begin
    stat_wr = wr_en && (sel == SEL_STAT);
    isr_wr  = wr_en && (sel == SEL_ISR);
    icr_wr  = wr_en && (sel == SEL_ICR);
    cmd     = CMD_NONE;
    if (wr_en && (sel == SEL_RCR)) begin
      if (cmd_bits[0])      cmd = CMD_FULL;
      else if (cmd_bits[1]) cmd = CMD_PART;
      else if (cmd_bits[2]) cmd = CMD_IRQCLR;
    end
  end
endmodule

// File: rtl/curc_init_seq.sv
module curc_init_seq #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  output logic          ready_q,
  output logic [AW-1:0] idx_q
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      ready_q <= 1'b0;
      idx_q   <= '0;
    end else if (!ready_q) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == LAST) ready_q <= 1'b1;
    end
  end
endmodule

// File: rtl/curc_param_mem.sv
module curc_param_mem #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 16,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/curc_irq_regs.sv
module curc_irq_regs
  import curc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic             clr_ctl,
  input  logic             clr_irq,
  input  logic             sw_en,
  input  logic [IRQ_W-1:0] evt,
  input  logic             isr_wr,
  input  logic             icr_wr,
  input  logic [IRQ_W-1:0] wbits,
  output logic [IRQ_W-1:0] isr_q,
  output logic [IRQ_W-1:0] icr_q,
  output logic [IRQ_W-1:0] irq_q
);
  logic [IRQ_W-1:0] icr_n;

  always_comb icr_n = (icr_wr && sw_en) ? wbits : icr_q;

  always_ff @(posedge clk) begin
    if (rst || clr_ctl) icr_q <= '0;
    else                icr_q <= icr_n;
  end

  for (genvar b = 0; b < IRQ_W; b++) begin : g_line
    logic clr_b, nxt_b, stat_r, line_r;
    always_comb begin
      clr_b = clr_irq || (isr_wr && sw_en && wbits[b]);
      nxt_b = (stat_r && !clr_b) || evt[b];
    end
    always_ff @(posedge clk) begin
      if (rst || clr_all) begin
        stat_r <= 1'b0;
        line_r <= 1'b0;
      end else begin
        stat_r <= nxt_b;
        line_r <= nxt_b && icr_n[b];
      end
    end
    assign isr_q[b] = stat_r;
    assign irq_q[b] = line_r;
  end
endmodule

// File: rtl/cipher_unit_rstctl.sv
module cipher_unit_rstctl
  import curc_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned PM_DEPTH = 64,
  parameter int unsigned PM_W     = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DW-1:0]               bus_wdata,
  output logic [DW-1:0]               bus_rdata,
  input  logic                        done_evt,
  output logic                        irq_done,
  output logic                        irq_err,
  output logic                        unit_ready,
  input  logic                        pm_we,
  input  logic [$clog2(PM_DEPTH)-1:0] pm_addr,
  input  logic [PM_W-1:0]             pm_wdata,
  output logic [PM_W-1:0]             pm_rdata
);
  localparam int unsigned PM_AW = $clog2(PM_DEPTH);

  reg_sel_e         sel;
  logic             addr_ok, wr_ok;
  rst_cmd_e         cmd;
  logic             stat_wr, isr_wr, icr_wr;
  logic             ready, restart;
  logic [PM_AW-1:0] init_idx;
  logic [IRQ_W-1:0] isr, icr, irq_lines;
  logic [DW-1:0]    rd_mux;
  logic             mem_we;
  logic [PM_AW-1:0] mem_addr;
  logic [PM_W-1:0]  mem_wdata;
  logic             unused_wdata;

  assign sel          = reg_sel_e'(bus_addr[3:2]);
  assign addr_ok      = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 4) == '0);
  assign wr_ok        = bus_wr && addr_ok;
  assign unused_wdata = ^bus_wdata;

  curc_cmd_decode u_dec (
    .wr_en   (wr_ok),
    .sel     (sel),
    .cmd_bits(bus_wdata[CMD_IRQ_BIT:CMD_FULL_BIT]),
    .cmd     (cmd),
    .stat_wr (stat_wr),
    .isr_wr  (isr_wr),
    .icr_wr  (icr_wr)
  );

  assign restart = (cmd == CMD_FULL) || (cmd == CMD_PART);

  curc_init_seq #(.DEPTH(PM_DEPTH), .AW(PM_AW)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .restart(restart),
    .ready_q(ready),
    .idx_q  (init_idx)
  );

  curc_irq_regs u_irq (
    .clk    (clk),
    .rst    (rst),
    .clr_all(restart),
    .clr_ctl(cmd == CMD_FULL),
    .clr_irq(cmd == CMD_IRQCLR),
    .sw_en  (ready),
    .evt    ({stat_wr, done_evt}),
    .isr_wr (isr_wr),
    .icr_wr (icr_wr),
    .wbits  (bus_wdata[IRQ_W-1:0]),
    .isr_q  (isr),
    .icr_q  (icr),
    .irq_q  (irq_lines)
  );

  assign irq_done   = irq_lines[IDX_DONE];
  assign irq_err    = irq_lines[IDX_AERR];
  assign unit_ready = ready;

  // sequencer owns the memory port until ready
  assign mem_we    = ready ? pm_we    : 1'b1;
  assign mem_addr  = ready ? pm_addr  : init_idx;
  assign mem_wdata = ready ? pm_wdata : '0;

  curc_param_mem #(.DEPTH(PM_DEPTH), .W(PM_W), .AW(PM_AW)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .addr (mem_addr),
    .wdata(mem_wdata),
    .rdata(pm_rdata)
  );

  always_comb begin
    rd_mux = '0;
    if (addr_ok) begin
      case (sel)
        SEL_STAT: rd_mux = DW'(ready);
        SEL_ISR:  rd_mux = DW'(isr);
        SEL_ICR:  rd_mux = DW'(icr);
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

module curc_checker
  import curc_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_ok,
  input logic          rd_ok,
  input reg_sel_e      sel,
  input logic [2:0]    cmd_bits,
  input logic          done_evt,
  input logic          irq_done,
  input logic          irq_err,
  input logic          ready,
  input logic [1:0]    isr,
  input logic [1:0]    icr,
  input logic [DW-1:0] rdata
);
  logic rcr_wr;
  assign rcr_wr = wr_ok && (sel == SEL_RCR);

  assert_done_line_R9: assert property (@(posedge clk) disable iff (rst)
    irq_done == (isr[0] && icr[0]));
  assert_err_line_R9: assert property (@(posedge clk) disable iff (rst)
    irq_err == (isr[1] && icr[1]));
  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (rst)
    (rcr_wr && (cmd_bits[0] || cmd_bits[1])) |=> !ready);
  assert_full_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (rcr_wr && cmd_bits[0]) |=> (icr == 2'b00 && isr == 2'b00 && !irq_done && !irq_err));
  assert_part_keeps_icr_R4: assert property (@(posedge clk) disable iff (rst)
    (rcr_wr && cmd_bits[1] && !cmd_bits[0]) |=> (icr == $past(icr) && isr == 2'b00));
  assert_irq_reset_R5: assert property (@(posedge clk) disable iff (rst)
    (rcr_wr && cmd_bits == 3'b100 && !done_evt) |=> (isr == 2'b00 && $stable(ready)));
  assert_rcr_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && sel == SEL_RCR) |=> rdata == '0);
  assert_addr_err_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && sel == SEL_STAT) |=> isr[1]);
  assert_icr_locked_R10: assert property (@(posedge clk) disable iff (rst)
    (!ready && wr_ok && sel == SEL_ICR) |=> $stable(icr));
  assert_done_sets_R11: assert property (@(posedge clk) disable iff (rst)
    (done_evt && !(rcr_wr && (cmd_bits[0] || cmd_bits[1]))) |=> isr[0]);
endmodule

bind cipher_unit_rstctl curc_checker #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_ok   (wr_ok),
  .rd_ok   (bus_rd && addr_ok),
  .sel     (sel),
  .cmd_bits(bus_wdata[26:24]),
  .done_evt(done_evt),
  .irq_done(irq_done),
  .irq_err (irq_err),
  .ready   (unit_ready),
  .isr     (isr),
  .icr     (icr),
  .rdata   (bus_rdata)
);

// File: tb/cipher_unit_rstctl_tb_top.sv
module cipher_unit_rstctl_tb_top;
  localparam logic [3:0]  A_RCR = 4'h0, A_STAT = 4'h4, A_ISR = 4'h8, A_ICR = 4'hC;
  localparam logic [31:0] C_IRQ = 32'h0400_0000, C_PART = 32'h0200_0000, C_FULL = 32'h0100_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 0, bus_rd = 0, done_evt = 0, pm_we = 0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_done, irq_err, unit_ready;
  logic [5:0]  pm_addr = '0;
  logic [15:0] pm_wdata = '0;
  logic [15:0] pm_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  logic [1:0] m_isr = 2'b00;
  logic [1:0] m_icr = 2'b00;

  always #2 clk = ~clk;

  cipher_unit_rstctl dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_evt(done_evt),
    .irq_done(irq_done), .irq_err(irq_err), .unit_ready(unit_ready),
    .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata), .pm_rdata(pm_rdata)
  );

  function automatic logic [1:0] isr_model(logic [1:0] cur, logic [1:0] clr, logic [1:0] set);
    return (cur & ~clr) | set;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input logic wr, input logic rd, input logic [3:0] a,
                        input logic [31:0] d, input logic dn);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; done_evt = dn;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; done_evt = 0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    bus_op(0, 1, a, '0, 0);
    chk(bus_rdata, exp, tag);
  endtask

  task automatic pm_write(input logic [5:0] a, input logic [15:0] d);
    pm_we = 1; pm_addr = a; pm_wdata = d;
    @(negedge clk);
    pm_we = 0;
  endtask

  task automatic pm_chk(input logic [5:0] a, input logic [15:0] exp, input string tag);
    pm_addr = a;
    @(negedge clk);
    chk(32'(pm_rdata), 32'(exp), tag);
  endtask

  // 'used' cycles already spent since the accepting edge
  task automatic wait_init(input int used, input string tag);
    repeat (63 - used) @(negedge clk);
    chk(32'(unit_ready), 0, tag);
    @(negedge clk);
    chk(32'(unit_ready), 1, tag);
  endtask

  task automatic chk_lines(input string tag);
    chk(32'(irq_done), 32'(m_isr[0] & m_icr[0]), tag);
    chk(32'(irq_err),  32'(m_isr[1] & m_icr[1]), tag);
  endtask

  initial begin
    #(4 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(bus_rdata, 0, "R1 rdata in reset");
    chk(32'(irq_done | irq_err), 0, "R1 lines in reset");
    chk(32'(unit_ready), 0, "R1 ready in reset");
    rst = 0;
    wait_init(0, "R2 init after hw reset");
    rd_chk(A_ISR, 0, "R1 isr after reset");
    rd_chk(A_ICR, 0, "R1 icr after reset");
    rd_chk(A_STAT, 1, "R2 status ready bit");

    // R7: no command bits, reads zero
    bus_op(1, 0, A_RCR, 32'hF8FF_FFFF, 0);
    @(negedge clk);
    chk(32'(unit_ready), 1, "R7 no-command write");
    rd_chk(A_RCR, 0, "R7 rcr reads zero");

    // R12 datapath memory port
    pm_write(6'd0, 16'h1111);
    pm_write(6'd5, 16'h2222);
    pm_write(6'd63, 16'hBEEF);
    pm_chk(6'd0, 16'h1111, "R12 readback 0");
    pm_chk(6'd5, 16'h2222, "R12 readback 5");
    pm_chk(6'd63, 16'hBEEF, "R12 readback 63");

    // R4 / R10 partial reset keeps enables, writes locked during init
    bus_op(1, 0, A_ICR, 32'h2, 0); m_icr = 2'b10;
    bus_op(0, 0, A_RCR, '0, 1);    m_isr = 2'b01;
    bus_op(1, 0, A_RCR, C_PART, 0); m_isr = 2'b00;
    chk(32'(unit_ready), 0, "R4 partial drops ready");
    chk_lines("R4 partial lines");
    bus_op(1, 0, A_ICR, 32'h1, 0);            // ignored
    bus_op(0, 0, A_RCR, '0, 1); m_isr = 2'b01; // event accepted
    bus_op(1, 0, A_ISR, 32'h1, 0);            // ignored
    rd_chk(A_ICR, 2, "R10 icr read during init");
    rd_chk(A_ISR, 1, "R10 isr read during init");
    repeat (35) @(negedge clk);
    pm_write(6'd0, 16'h1234);                 // ignored, 41 cycles used
    wait_init(41, "R2 init after partial");
    rd_chk(A_ICR, 2, "R4 icr kept");
    rd_chk(A_ISR, 1, "R10 isr clear ignored");
    pm_chk(6'd0, 0, "R2 entry 0 zero");
    pm_chk(6'd5, 0, "R2 entry 5 zero");
    pm_chk(6'd63, 0, "R12 entry 63 zero");
    bus_op(1, 0, A_ISR, 32'h1, 0); m_isr = 2'b00;
    rd_chk(A_ISR, 0, "R10 w1c when ready");

    // R3 full reset
    bus_op(1, 0, A_ICR, 32'h3, 0); m_icr = 2'b11;
    bus_op(0, 0, A_RCR, '0, 1);    m_isr = 2'b01;
    chk(32'(irq_done), 1, "R9 done line raised");
    bus_op(1, 0, A_RCR, C_FULL, 0); m_isr = 0; m_icr = 0;
    chk(32'(unit_ready), 0, "R3 full drops ready");
    chk(32'(irq_done), 0, "R3 full clears line");
    wait_init(0, "R3 init after full");
    rd_chk(A_ICR, 0, "R3 icr cleared");
    rd_chk(A_ISR, 0, "R3 isr cleared");

    // R6 priority
    bus_op(1, 0, A_ICR, 32'h3, 0); m_icr = 2'b11;
    bus_op(1, 0, A_RCR, C_IRQ | C_PART, 0);
    chk(32'(unit_ready), 0, "R6 irq+part acts as partial");
    wait_init(0, "R6 init irq+part");
    rd_chk(A_ICR, 3, "R6 partial keeps icr");
    bus_op(1, 0, A_RCR, C_IRQ | C_FULL, 0);
    wait_init(0, "R6 init irq+full");
    rd_chk(A_ICR, 0, "R6 irq+full acts as full");
    bus_op(1, 0, A_ICR, 32'h3, 0);
    bus_op(1, 0, A_RCR, C_IRQ | C_PART | C_FULL, 0);
    wait_init(0, "R6 init all bits");
    rd_chk(A_ICR, 0, "R6 all bits acts as full");

    // R5 / R8 interrupt reset and address error
    bus_op(1, 0, A_ICR, 32'h3, 0); m_icr = 2'b11;
    bus_op(0, 0, A_RCR, '0, 1);
    bus_op(1, 0, A_STAT, 32'h0, 0); m_isr = 2'b11;
    chk(32'(irq_err), 1, "R8 error line");
    chk(32'(irq_done), 1, "R9 done line");
    rd_chk(A_STAT, 1, "R8 status unchanged");
    bus_op(1, 0, A_RCR, C_IRQ, 0); m_isr = 0;
    chk_lines("R5 lines cleared");
    chk(32'(unit_ready), 1, "R5 ready unchanged");
    rd_chk(A_ISR, 0, "R5 isr cleared");
    rd_chk(A_ICR, 3, "R5 icr unchanged");

    // R11 same-cycle set versus clear
    bus_op(1, 0, A_RCR, C_IRQ, 1); m_isr = 2'b01;
    chk(32'(irq_done), 1, "R11 done wins over irq reset");
    bus_op(1, 0, A_ISR, 32'h1, 1);
    rd_chk(A_ISR, 1, "R11 done wins over w1c");

    // random phase
    for (int i = 0; i < 400; i++) begin
      int unsigned op = $urandom_range(0, 5);
      logic [31:0] v = $urandom;
      logic dn = ($urandom_range(0, 3) == 0);
      case (op)
        0: begin bus_op(1, 0, A_ICR, v, dn); m_icr = v[1:0];
                 m_isr = isr_model(m_isr, 2'b00, {1'b0, dn}); end
        1: begin bus_op(1, 0, A_ISR, v, dn);
                 m_isr = isr_model(m_isr, v[1:0], {1'b0, dn}); end
        2: begin bus_op(1, 0, A_STAT, v, dn);
                 m_isr = isr_model(m_isr, 2'b00, {1'b1, dn}); end
        3: begin bus_op(1, 0, A_RCR, C_IRQ, dn);
                 m_isr = isr_model(m_isr, 2'b11, {1'b0, dn}); end
        4: begin bus_op(0, 0, A_RCR, '0, 1);
                 m_isr = isr_model(m_isr, 2'b00, 2'b01); end
        default: begin
          rd_chk(A_ISR, 32'(m_isr), "R11 random isr");
          rd_chk(A_ICR, 32'(m_icr), "R10 random icr");
          rd_chk(A_STAT, 1, "R8 random status");
        end
      endcase
      chk_lines("R9 random lines");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule